// File: doc/BRIEF.md
# Vector Element Interleave Unit

This block executes one vector permutation: it takes two source register groups and builds a destination group twice as long, alternating elements between them. Destination slot 0 takes element 0 of source A (the register named in the vs2 field), slot 1 takes element 0 of source B (the vs1 field), slot 2 takes element 1 of source A, and so on. Because the destination holds twice as many elements, the destination group multiplier is one power of two above the source multiplier, and the number of processed elements is twice the programmed vector length.

The unit takes the 32-bit instruction word, the element width code, the signed group-multiplier exponent, the vector length, the mask bits and flat copies of both source groups and the old destination group. It decodes the word and decides legality, covering the opcode, element width, multiplier and register-group placement. It then applies per-element masking with an undisturbed policy and registers the outcome one clock after the issue strobe. Register storage and restart state live outside the block.

Top module: `vzip_unit`

## Requirements
- R1: For every active destination element i (element i occupies bits i*EW .. i*EW+EW-1, EW the element width), the result is source-A element i/2 when i is even and source-B element i/2 when i is odd.
- R2: Only elements with index below twice `vl_i` and below the destination group capacity are written; every other element keeps its old destination value. With `vl_i` of 0 the result equals the old destination while `wr_en_o` still rises.
- R3: With instruction bit 25 clear, element i is written only when `mask_i[i]` is 1, and elements with a clear mask bit keep their old value. With bit 25 set, every element is active whatever `mask_i` holds.
- R4: The word is accepted only when bits 31:26 are 111110, bits 14:12 are 010 and bits 6:0 are 1010111; any other word raises illegal.
- R5: Width code 0/1/2/3 selects 8/16/32/64-bit elements. Code 3 raises illegal unless `e64_en_i` is 1.
- R6: Source multiplier exponent 3 and the reserved encoding -4 raise illegal. For other exponents the destination group spans 2^(exponent+1) registers (at least one), and its capacity is VLEN*2^(exponent+1)/EW elements.
- R7: The destination number (bits 11:7) must be a multiple of the destination group size, and each source number (bits 24:20 and 19:15) a multiple of the source group size. A source group may overlap the destination group only when the source exponent is 0 or more and the source occupies the top registers of the destination group. Any other placement raises illegal.
- R8: With bit 25 clear and destination register 0, the instruction is illegal.
- R9: `done_o` pulses for exactly the cycle after each issue. `wr_en_o` and `illegal_o` in that cycle are exclusive and one of them is set. An illegal issue returns the old destination unchanged.
- R10: After synchronous reset, `done_o`, `wr_en_o`, `illegal_o` and `result_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Start strobe; operands sampled on this edge |
| instr_i | input | 32 | Instruction word |
| sew_i | input | 2 | Element width code (0=8, 1=16, 2=32, 3=64) |
| lmul_i | input | 3 | Signed source group multiplier exponent |
| vl_i | input | $clog2(VLEN+1) | Programmed vector length (source elements) |
| e64_en_i | input | 1 | 64-bit elements permitted |
| mask_i | input | VLEN | Per-destination-element mask bits |
| src_a_i | input | 4*VLEN | Source group named by bits 24:20 |
| src_b_i | input | 4*VLEN | Source group named by bits 19:15 |
| old_dst_i | input | 8*VLEN | Current destination group contents |
| result_o | output | 8*VLEN | Registered destination group value |
| wr_en_o | output | 1 | Result should be written back |
| illegal_o | output | 1 | Instruction rejected |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that a legal issue never carries a vector length above the source group capacity, VLEN*2^exponent/EW. The unit does not clamp such a length, so the property that guards this treats it as an input contract. The stimulus draws every length from zero up to that capacity, recomputed from the width and exponent of the same operation. Register numbers are mostly aligned to the group size so that legal issues dominate. A share are left raw, and the instruction fields are corrupted at low probability, so the illegal paths still occur.

// File: rtl/vzip_pkg.sv
package vzip_pkg;

  localparam logic [5:0] ZIP_FUNCT6 = 6'b111110;
  localparam logic [2:0] ZIP_FUNCT3 = 3'b010;
  localparam logic [6:0] ZIP_MAJOR  = 7'b1010111;

  typedef enum logic [1:0] {
    EW8  = 2'd0,
    EW16 = 2'd1,
    EW32 = 2'd2,
    EW64 = 2'd3
  } ew_e;

  typedef struct packed {
    logic [5:0] funct6;
    logic       unmasked;
    logic [4:0] rs_a;
    logic [4:0] rs_b;
    logic [2:0] funct3;
    logic [4:0] rd;
    logic [6:0] major;
  } zip_instr_t;

  // bits held by a register group of multiplier 2^e
  function automatic logic [31:0] group_bits(int unsigned vlen, int e);
    if (e >= 0) return 32'(vlen) << e;
    else        return 32'(vlen) >> (-e);
  endfunction

  // architectural registers spanned by a group of multiplier 2^e
  function automatic logic [6:0] group_regs(int e);
    if (e <= 0) return 7'd1;
    else        return 7'd1 << e;
  endfunction

endpackage

// File: rtl/vzip_decode.sv
module vzip_decode
  import vzip_pkg::*;
(
  input  logic [31:0] instr_i,
  output zip_instr_t  fields_o,
  output logic        match_o
);

  assign fields_o = zip_instr_t'(instr_i);

  always_comb begin
    match_o = (fields_o.funct6 == ZIP_FUNCT6) &&
              (fields_o.funct3 == ZIP_FUNCT3) &&
              (fields_o.major  == ZIP_MAJOR);
  end

endmodule

// File: rtl/vzip_legal.sv
module vzip_legal
  import vzip_pkg::*;
(
  input  zip_instr_t        fields_i,
  input  logic              match_i,
  input  logic [1:0]        sew_i,
  input  logic signed [2:0] lmul_i,
  input  logic              e64_en_i,
  output logic              illegal_o
);

  int         lexp;
  logic [6:0] n_src, n_dst;
  logic [6:0] rd7, ra7, rb7;
  logic       aligned, a_ok, b_ok, width_bad, lmul_bad, v0_bad;

  // source group placement check against the widened destination group
  function automatic logic place_ok(logic [6:0] s, logic [6:0] d,
                                    logic [6:0] ns, logic [6:0] nd,
                                    logic whole_src);
    logic hit;
    hit = (s < d + nd) && (d < s + ns);
    return !hit || (whole_src && (s + ns == d + nd));
  endfunction

  always_comb begin
    lexp  = int'(lmul_i);
    n_src = group_regs(lexp);
    n_dst = group_regs(lexp + 1);
    rd7   = {2'b00, fields_i.rd};
    ra7   = {2'b00, fields_i.rs_a};
    rb7   = {2'b00, fields_i.rs_b};

    aligned = ((rd7 & (n_dst - 7'd1)) == 7'd0) &&
              ((ra7 & (n_src - 7'd1)) == 7'd0) &&
              ((rb7 & (n_src - 7'd1)) == 7'd0);
    a_ok = place_ok(ra7, rd7, n_src, n_dst, lexp >= 0);
    b_ok = place_ok(rb7, rd7, n_src, n_dst, lexp >= 0);

    width_bad = (ew_e'(sew_i) == EW64) && !e64_en_i;
    lmul_bad  = (lmul_i == 3'sd3) || (lmul_i == -3'sd4);
    v0_bad    = !fields_i.unmasked && (fields_i.rd == 5'd0);

    illegal_o = !match_i || width_bad || lmul_bad || v0_bad ||
                !aligned || !a_ok || !b_ok;
  end

endmodule

// File: rtl/vzip_permute.sv
module vzip_permute #(
  parameter int VLEN  = 128,
  parameter int SRC_W = 4 * VLEN,
  parameter int DST_W = 8 * VLEN,
  parameter int EVL_W = 9
) (
  input  logic [1:0]       sew_i,
  input  logic [EVL_W-1:0] evl_i,
  input  logic [15:0]      ndst_i,
  input  logic             unmasked_i,
  input  logic [VLEN-1:0]  mask_i,
  input  logic [SRC_W-1:0] a_i,
  input  logic [SRC_W-1:0] b_i,
  input  logic [DST_W-1:0] old_i,
  output logic [DST_W-1:0] res_o
);

  localparam int N_WIDTHS = 4;

  logic [DST_W-1:0] cand [N_WIDTHS];

  for (genvar k = 0; k < N_WIDTHS; k++) begin : g_width
    localparam int EW = 8 << k;
    localparam int NE = DST_W / EW;
    logic [DST_W-1:0] v;

    for (genvar i = 0; i < NE; i++) begin : g_elem
      logic          act;
      logic [EW-1:0] pick;

      assign act = (EVL_W'(i) < evl_i) && (16'(i) < ndst_i) &&
                   (unmasked_i || mask_i[i]);

      if (i % 2 == 0) begin : g_even
        assign pick = a_i[(i/2)*EW +: EW];
      end else begin : g_odd
        assign pick = b_i[(i/2)*EW +: EW];
      end

      assign v[i*EW +: EW] = act ? pick : old_i[i*EW +: EW];
    end

    assign cand[k] = v;
  end

  assign res_o = cand[sew_i];

endmodule

// File: rtl/vzip_unit.sv
module vzip_unit
  import vzip_pkg::*;
#(
  parameter int VLEN = 128,
  localparam int SRC_W = 4 * VLEN,
  localparam int DST_W = 8 * VLEN,
  localparam int VL_W  = $clog2(VLEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_i,
  input  logic [31:0]       instr_i,
  input  logic [1:0]        sew_i,
  input  logic signed [2:0] lmul_i,
  input  logic [VL_W-1:0]   vl_i,
  input  logic              e64_en_i,
  input  logic [VLEN-1:0]   mask_i,
  input  logic [SRC_W-1:0]  src_a_i,
  input  logic [SRC_W-1:0]  src_b_i,
  input  logic [DST_W-1:0]  old_dst_i,
  output logic [DST_W-1:0]  result_o,
  output logic              wr_en_o,
  output logic              illegal_o,
  output logic              done_o
);

  localparam int EVL_W = VL_W + 1;

  zip_instr_t       fields;
  logic             match;
  logic             illegal_c;
  logic [EVL_W-1:0] evl;
  logic [31:0]      src_elems, dst_elems;
  logic [DST_W-1:0] perm;
  int               lexp;

  vzip_decode u_decode (
    .instr_i  (instr_i),
    .fields_o (fields),
    .match_o  (match)
  );

  vzip_legal u_legal (
    .fields_i  (fields),
    .match_i   (match),
    .sew_i     (sew_i),
    .lmul_i    (lmul_i),
    .e64_en_i  (e64_en_i),
    .illegal_o (illegal_c)
  );

  always_comb begin
    lexp      = int'(lmul_i);
    evl       = {vl_i, 1'b0};
    src_elems = group_bits(VLEN, lexp)     >> (3 + int'(sew_i));
    dst_elems = group_bits(VLEN, lexp + 1) >> (3 + int'(sew_i));
  end

  vzip_permute #(
    .VLEN  (VLEN),
    .SRC_W (SRC_W),
    .DST_W (DST_W),
    .EVL_W (EVL_W)
  ) u_permute (
    .sew_i      (sew_i),
    .evl_i      (evl),
    .ndst_i     (dst_elems[15:0]),
    .unmasked_i (fields.unmasked),
    .mask_i     (mask_i),
    .a_i        (src_a_i),
    .b_i        (src_b_i),
    .old_i      (old_dst_i),
    .res_o      (perm)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o  <= '0;
      wr_en_o   <= 1'b0;
      illegal_o <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      done_o    <= issue_i;
      wr_en_o   <= issue_i && !illegal_c;
      illegal_o <= issue_i && illegal_c;
      if (issue_i) result_o <= illegal_c ? old_dst_i : perm;
    end
  end

  // input contract: a legal issue keeps vl within the source group
  assert_vl_in_group_R2: assert property (@(posedge clk) disable iff (rst)
    (issue_i && !illegal_c) |-> (32'(vl_i) <= src_elems));

  assert_opcode_reject_R4: assert property (@(posedge clk) disable iff (rst)
    (issue_i && (instr_i[6:0] != 7'b1010111)) |=> illegal_o);

  assert_e64_gate_R5: assert property (@(posedge clk) disable iff (rst)
    (issue_i && (sew_i == 2'd3) && !e64_en_i) |=> illegal_o);

  assert_lmul8_reject_R6: assert property (@(posedge clk) disable iff (rst)
    (issue_i && (lmul_i == 3'sd3)) |=> illegal_o);

  assert_mask_dest_v0_R8: assert property (@(posedge clk) disable iff (rst)
    (issue_i && !instr_i[25] && (instr_i[11:7] == 5'd0)) |=> illegal_o);

  assert_done_after_issue_R9: assert property (@(posedge clk) disable iff (rst)
    issue_i |=> done_o);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    !issue_i |=> !done_o);

  assert_wr_excl_R9: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> (done_o && !illegal_o));

  assert_illegal_keeps_old_R9: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (result_o == $past(old_dst_i)));

endmodule

// File: tb/vzip_unit_bench.sv
`timescale 1ns/1ps
module vzip_unit_bench;

  localparam int VLEN  = 128;
  localparam int SRC_W = 4 * VLEN;
  localparam int DST_W = 8 * VLEN;
  localparam int VL_W  = $clog2(VLEN + 1);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              issue = 1'b0;
  logic [31:0]       instr = '0;
  logic [1:0]        sew = '0;
  logic signed [2:0] lmul = '0;
  logic [VL_W-1:0]   vl = '0;
  logic              e64 = 1'b0;
  logic [VLEN-1:0]   mask = '0;
  logic [SRC_W-1:0]  src_a = '0, src_b = '0;
  logic [DST_W-1:0]  old_dst = '0;
  logic [DST_W-1:0]  result;
  logic              wr_en, illegal, done;

  int n_checks = 0;
  int n_errs   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  vzip_unit #(.VLEN(VLEN)) u_vzip_unit (
    .clk(clk), .rst(rst), .issue_i(issue), .instr_i(instr), .sew_i(sew),
    .lmul_i(lmul), .vl_i(vl), .e64_en_i(e64), .mask_i(mask),
    .src_a_i(src_a), .src_b_i(src_b), .old_dst_i(old_dst),
    .result_o(result), .wr_en_o(wr_en), .illegal_o(illegal), .done_o(done)
  );

  task automatic check(string req, string what,
                       logic [DST_W-1:0] act, logic [DST_W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_instr(bit vm, int vs2, int vs1, int vd);
    return {6'b111110, vm, 5'(vs2), 5'(vs1), 3'b010, 5'(vd), 7'b1010111};
  endfunction

  function automatic int grp_regs(int e);
    return (e <= 0) ? 1 : (1 << e);
  endfunction

  function automatic int capacity(int e, int sw);
    int bits;
    bits = (e >= 0) ? (VLEN << e) : (VLEN >> (-e));
    return bits / (8 << sw);
  endfunction

  // legality model from the requirements (R4..R8)
  function automatic bit exp_illegal(logic [31:0] ins, int sw, int lm, bit en64);
    int vd, va, vb, ns, nd;
    int srcs [2];
    if (ins[31:26] != 6'b111110 || ins[14:12] != 3'b010 || ins[6:0] != 7'b1010111)
      return 1'b1;
    if (sw == 3 && !en64) return 1'b1;
    if (lm == 3 || lm == -4) return 1'b1;
    vd = int'(ins[11:7]); va = int'(ins[24:20]); vb = int'(ins[19:15]);
    ns = grp_regs(lm); nd = grp_regs(lm + 1);
    if (!ins[25] && vd == 0) return 1'b1;
    if ((vd % nd) != 0 || (va % ns) != 0 || (vb % ns) != 0) return 1'b1;
    srcs[0] = va; srcs[1] = vb;
    foreach (srcs[s]) begin
      bit hit = 1'b0;
      for (int r = srcs[s]; r < srcs[s] + ns; r++)
        if (r >= vd && r < vd + nd) hit = 1'b1;
      if (hit && !(lm >= 0 && srcs[s] + ns == vd + nd)) return 1'b1;
    end
    return 1'b0;
  endfunction

  // data model from R1..R3
  function automatic logic [DST_W-1:0] exp_result(
      logic [31:0] ins, int sw, int lm, int vlen_prog, logic [VLEN-1:0] m,
      logic [SRC_W-1:0] a, logic [SRC_W-1:0] b, logic [DST_W-1:0] old);
    logic [DST_W-1:0] r;
    int ew, ndst;
    r = old;
    ew = 8 << sw;
    ndst = capacity(lm + 1, sw);
    for (int i = 0; i < DST_W / ew; i++) begin
      bit act = (i < 2 * vlen_prog) && (i < ndst) && (ins[25] || m[i]);
      if (act)
        for (int k = 0; k < ew; k++)
          r[i*ew + k] = (i % 2 == 0) ? a[(i/2)*ew + k] : b[(i/2)*ew + k];
    end
    return r;
  endfunction

  function automatic logic [DST_W-1:0] rnd_vec();
    logic [DST_W-1:0] r;
    for (int w = 0; w < DST_W / 32; w++) r[w*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic run_op(string req, logic [31:0] ins, int sw, int lm, int vlp,
                        bit en64, logic [VLEN-1:0] m);
    logic [DST_W-1:0] ra, rb, ro, er;
    bit ei;
    ra = rnd_vec(); rb = rnd_vec(); ro = rnd_vec();
    @(negedge clk);
    instr = ins; sew = 2'(sw); lmul = 3'(lm); vl = VL_W'(vlp); e64 = en64;
    mask = m; src_a = ra[SRC_W-1:0]; src_b = rb[SRC_W-1:0]; old_dst = ro;
    issue = 1'b1;
    ei = exp_illegal(ins, sw, lm, en64);
    er = ei ? ro : exp_result(ins, sw, lm, vlp, m, ra[SRC_W-1:0], rb[SRC_W-1:0], ro);
    @(negedge clk);
    issue = 1'b0;
    old_dst = rnd_vec();
    check("R9", "done", DST_W'(done), DST_W'(1'b1));
    check(req, "illegal", DST_W'(illegal), DST_W'(ei));
    check("R9", "wr_en", DST_W'(wr_en), DST_W'(!ei));
    check(req, "result", result, er);
    @(negedge clk);
    check("R9", "done low", DST_W'(done), DST_W'(1'b0));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check("R10", "result", result, '0);
    check("R10", "flags", DST_W'({done, wr_en, illegal}), '0);

    // R1: full-length interleave, bytes, unmasked
    run_op("R1", mk_instr(1, 8, 10, 4), 0, 0, 16, 1, '0);
    run_op("R1", mk_instr(1, 12, 16, 8), 1, 1, 16, 1, '0);
    // R2: short length leaves the tail, and vl zero writes nothing
    run_op("R2", mk_instr(1, 8, 10, 4), 2, 0, 1, 1, '1);
    run_op("R2", mk_instr(1, 8, 10, 4), 0, 0, 0, 1, '1);
    // R3: masked and unmasked with an all-zero mask
    run_op("R3", mk_instr(0, 8, 10, 4), 0, 0, 16, 1, {4{32'hA5C3_0F96}});
    run_op("R3", mk_instr(1, 8, 10, 4), 0, 0, 16, 1, '0);
    // R4: wrong function code and wrong major opcode
    run_op("R4", mk_instr(1, 8, 10, 4) ^ 32'h0400_0000, 0, 0, 4, 1, '1);
    run_op("R4", mk_instr(1, 8, 10, 4) ^ 32'h0000_0001, 0, 0, 4, 1, '1);
    // R5: 64-bit elements gated by the enable
    run_op("R5", mk_instr(1, 8, 10, 4), 3, 0, 2, 0, '1);
    run_op("R5", mk_instr(1, 8, 10, 4), 3, 0, 2, 1, '1);
    // R6: multiplier 8, reserved code, fractional source
    run_op("R6", mk_instr(1, 8, 16, 0), 0, 3, 4, 1, '1);
    run_op("R6", mk_instr(1, 8, 10, 4), 0, -4, 0, 1, '1);
    run_op("R6", mk_instr(1, 8, 10, 4), 0, -1, 8, 1, '1);
    // R7: permitted top overlap, forbidden overlaps, misalignment
    run_op("R7", mk_instr(1, 5, 10, 4), 0, 0, 16, 1, '1);
    run_op("R7", mk_instr(1, 4, 10, 4), 0, 0, 16, 1, '1);
    run_op("R7", mk_instr(1, 4, 10, 4), 0, -1, 4, 1, '1);
    run_op("R7", mk_instr(1, 8, 10, 3), 0, 0, 4, 1, '1);
    run_op("R7", mk_instr(1, 10, 12, 8), 0, 2, 8, 1, '1);
    // R8: masked write into register 0
    run_op("R8", mk_instr(0, 8, 10, 0), 0, 0, 4, 1, '1);

    // constrained random mix (R1)
    for (int t = 0; t < 300; t++) begin
      int sw, lm, cap, vlp, vd, va, vb, ns, nd;
      bit en64, vm;
      logic [31:0] ins;
      logic [VLEN-1:0] m;
      sw = int'($urandom % 4);
      lm = int'($urandom % 7) - 3;
      if ($urandom % 16 == 0) lm = 3;
      en64 = ($urandom % 4) != 0;
      vm = $urandom % 2;
      cap = (lm == 3) ? 8 : capacity(lm, sw);
      vlp = int'($urandom % (cap + 1));
      ns = grp_regs(lm); nd = grp_regs(lm + 1);
      vd = int'($urandom % 32); va = int'($urandom % 32); vb = int'($urandom % 32);
      if ($urandom % 8 != 0) begin
        vd = vd & ~(nd - 1); va = va & ~(ns - 1); vb = vb & ~(ns - 1);
      end
      ins = mk_instr(vm, va, vb, vd);
      if ($urandom % 16 == 0) ins = ins ^ (32'h1 << ($urandom % 32));
      for (int w = 0; w < VLEN / 32; w++) m[w*32 +: 32] = $urandom;
      run_op("R1", ins, sw, lm, vlp, en64, m);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_errs++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
      $finish;
    end
  end

endmodule